// File: doc/BRIEF.md
# Lockable Reset Watchdog Timer

This block supervises software with a 16-bit up-counter. The counter advances once every 2 or once every 128 system clocks, depending on a prescaler select. Software proves it is alive by pulsing a service strobe. The strobe reloads the counter's upper byte from a programmable reload register and clears the lower byte and the prescaler phase. If software fails to service the counter before it passes 0xFFFF, the block raises an internal reset request and drives an active-low reset output for a fixed number of clocks. After that it releases both with the counter cleared. A sticky cause flag records that this happened. Only a power-on reset clears the flag.

The watchdog runs from every reset with the fast prescaler and a reload value of zero. Until software signals end of initialization, it may disable the watchdog or rewrite the reload value and the prescaler select. The end-of-initialization strobe locks the enable and the configuration until the next reset.

All inputs are plain single-cycle strobes or levels sampled on the rising clock edge. The block carries no streaming data, so it has no valid/ready handshake and no back-pressure.

Top module: `wdog_lockable`

## Requirements
- R1: After reset (rst_n or por_n low), count_o reads 0, rst_out_n_o is 1, reset_req_o is 0, the watchdog is enabled, the prescaler select is fast and the reload value is 0x00. A power-on reset also clears wdt_cause_o to 0.
- R2: With the fast prescaler (cfg_slow_i = 0), count_o rises by one on every second clock edge. Counting from a service strobe accepted at edge E0, the increments land on E2, E4, and so on.
- R3: With the slow prescaler (cfg_slow_i = 1), count_o rises by one on every 128th clock edge after a service strobe.
- R4: A service strobe accepted outside a reset pulse loads count_o with {reload, 8'h00} on that edge and restarts the prescaler phase.
- R5: If the counter is not serviced, rst_out_n_o falls exactly (65536 - 256*reload) * divider clocks after the service edge, where the divider is 2 or 128. It falls on the edge where a tick finds count_o at 0xFFFF, and at no other time.
- R6: The reset pulse holds rst_out_n_o low and reset_req_o high for exactly 16 clocks. At the end both release, with count_o at 0.
- R7: A disable strobe accepted before end of initialization stops the counter. count_o then holds its value and no reset pulse occurs.
- R8: After the end-of-initialization strobe, disable strobes have no effect, and counting continues.
- R9: After the end-of-initialization strobe, configuration writes (cfg_we_i) change neither the reload value nor the prescaler select.
- R10: wdt_cause_o goes to 1 when a reset pulse starts. A later rst_n reset leaves it at 1; only por_n low clears it.
- R11: A service strobe on the same edge as a 0xFFFF tick wins. The counter reloads and no reset pulse starts.
- R12: During a reset pulse, service strobes are ignored: count_o stays 0 and the pulse length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| por_n | input | 1 | Asynchronous active-low power-on reset; also clears the cause flag |
| svc_i | input | 1 | Service strobe |
| einit_i | input | 1 | End-of-initialization strobe; locks enable and configuration |
| dis_i | input | 1 | Disable strobe, honoured only before lock |
| cfg_we_i | input | 1 | Configuration write strobe, honoured only before lock |
| cfg_slow_i | input | 1 | Prescaler select written by cfg_we_i: 0 = divide by 2, 1 = divide by 128 |
| cfg_reload_i | input | 8 | Reload value for the counter's upper byte, written by cfg_we_i |
| count_o | output | 16 | Current counter value |
| reset_req_o | output | 1 | Internal reset request, high during the reset pulse |
| rst_out_n_o | output | 1 | Active-low reset output for external devices |
| wdt_cause_o | output | 1 | Sticky flag: a watchdog reset has occurred since power-on |

## Verification
The counting function is driven in both prescaler modes. The counter is sampled at edges just before and just after the expected increments, which separates a correct divider from one that is off by one or uses the wrong phase. Full overflow runs with reload 0xFF in both modes fix the absolute interval and the exact edge where the reset output falls. A separate run places a service strobe on the very edge of the 0xFFFF tick, which shows whether servicing takes priority over overflow. Disable and configuration strobes are applied both before and after the lock. Their effect, or lack of effect, is read back through the counter's value and rate. The cause flag is exercised against both kinds of reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  parameter int unsigned WDG_CNT_W      = 16;
  parameter int unsigned WDG_REL_W      = 8;
  parameter int unsigned WDG_FAST_LOG2  = 1;
  parameter int unsigned WDG_SLOW_LOG2  = 7;
  parameter int unsigned WDG_RST_CYCLES = 16;

  typedef enum logic {
    PRE_FAST = 1'b0,
    PRE_SLOW = 1'b1
  } presel_e;
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int unsigned REL_W = WDG_REL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dis_i,
  input  logic             einit_i,
  input  logic             cfg_we_i,
  input  logic             cfg_slow_i,
  input  logic [REL_W-1:0] cfg_reload_i,
  output logic             enabled_o,
  output logic             locked_o,
  output presel_e          presel_o,
  output logic [REL_W-1:0] reload_o
);
  logic             enabled_q;
  logic             locked_q;
  presel_e          presel_q;
  logic [REL_W-1:0] reload_q;

  // Writes in the same cycle as einit_i are still accepted, because the lock is registered.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled_q <= 1'b1;
      locked_q  <= 1'b0;
      presel_q  <= PRE_FAST;
      reload_q  <= '0;
    end else begin
      if (einit_i) locked_q <= 1'b1;
      if (!locked_q && dis_i) enabled_q <= 1'b0;
      if (!locked_q && cfg_we_i) begin
        presel_q <= cfg_slow_i ? PRE_SLOW : PRE_FAST;
        reload_q <= cfg_reload_i;
      end
    end
  end

  assign enabled_o = enabled_q;
  assign locked_o  = locked_q;
  assign presel_o  = presel_q;
  assign reload_o  = reload_q;

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> ($stable(reload_q) && $stable(presel_q)));
  assert_no_reenable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled_q |=> !enabled_q);
  assert_enable_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && enabled_q) |=> enabled_q);
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int unsigned FAST_LOG2 = WDG_FAST_LOG2,
  parameter int unsigned SLOW_LOG2 = WDG_SLOW_LOG2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run_i,
  input  logic    clear_i,
  input  presel_e presel_i,
  output logic    tick_o
);
  localparam int unsigned PH_W = (SLOW_LOG2 > 0) ? SLOW_LOG2 : 1;

  logic [PH_W-1:0] phase_q;
  logic            fast_hit;
  logic            slow_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (clear_i)  phase_q <= '0;
    else if (run_i)    phase_q <= phase_q + 1'b1;
  end

  generate
    if (FAST_LOG2 == 0) begin : g_fast_every
      assign fast_hit = 1'b1;
    end else begin : g_fast_div
      assign fast_hit = &phase_q[FAST_LOG2-1:0];
    end
    if (SLOW_LOG2 == 0) begin : g_slow_every
      assign slow_hit = 1'b1;
    end else begin : g_slow_div
      assign slow_hit = &phase_q[SLOW_LOG2-1:0];
    end
  endgenerate

  assign tick_o = run_i && !clear_i && ((presel_i == PRE_SLOW) ? slow_hit : fast_hit);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = WDG_CNT_W,
  parameter int unsigned REL_W = WDG_REL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             svc_i,
  input  logic             tick_i,
  input  logic [REL_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam int unsigned LOW_W = CNT_W - REL_W;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (hold_i)  count_q <= '0;
    else if (svc_i)   count_q <= {reload_i, {LOW_W{1'b0}}};
    else if (tick_i)  count_q <= count_q + 1'b1;
  end

  // Servicing wins over a terminal tick on the same edge.
  assign ovf_o   = tick_i && !svc_i && !hold_i && (&count_q);
  assign count_o = count_q;
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse
  import wdog_pkg::*;
#(
  parameter int unsigned RST_CYCLES = WDG_RST_CYCLES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_n,
  input  logic ovf_i,
  output logic active_o,
  output logic cause_o
);
  localparam int unsigned PW = $clog2(RST_CYCLES + 1);

  logic [PW-1:0] left_q;
  logic          cause_q;
  logic [PW:0]   chk_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (ovf_i)          left_q <= PW'(RST_CYCLES);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cause_q <= 1'b0;
    else if (ovf_i)  cause_q <= 1'b1;
  end

  assign active_o = (left_q != '0);
  assign cause_o  = cause_q;

  // Checker: length of the current low phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chk_len <= '0;
    else if (active_o)  chk_len <= chk_len + 1'b1;
    else                chk_len <= '0;
  end

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> (chk_len == (PW+1)'(RST_CYCLES)));
  assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
    cause_q |=> cause_q);
  assert_cause_on_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> cause_q);
endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W      = WDG_CNT_W,
  parameter int unsigned REL_W      = WDG_REL_W,
  parameter int unsigned FAST_LOG2  = WDG_FAST_LOG2,
  parameter int unsigned SLOW_LOG2  = WDG_SLOW_LOG2,
  parameter int unsigned RST_CYCLES = WDG_RST_CYCLES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             svc_i,
  input  logic             einit_i,
  input  logic             dis_i,
  input  logic             cfg_we_i,
  input  logic             cfg_slow_i,
  input  logic [REL_W-1:0] cfg_reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             reset_req_o,
  output logic             rst_out_n_o,
  output logic             wdt_cause_o
);
  localparam int unsigned LOW_W = CNT_W - REL_W;

  logic             rst_sys_n;
  logic             enabled;
  logic             locked;
  presel_e          presel;
  logic [REL_W-1:0] reload;
  logic             in_pulse;
  logic             run;
  logic             tick;
  logic             ovf;

  assign rst_sys_n = rst_n & por_n;
  assign run       = enabled && !in_pulse;

  wdog_cfg #(.REL_W(REL_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_sys_n),
    .dis_i        (dis_i),
    .einit_i      (einit_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_slow_i   (cfg_slow_i),
    .cfg_reload_i (cfg_reload_i),
    .enabled_o    (enabled),
    .locked_o     (locked),
    .presel_o     (presel),
    .reload_o     (reload)
  );

  wdog_prescaler #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_pre (
    .clk      (clk),
    .rst_n    (rst_sys_n),
    .run_i    (run),
    .clear_i  (svc_i || in_pulse),
    .presel_i (presel),
    .tick_o   (tick)
  );

  wdog_counter #(.CNT_W(CNT_W), .REL_W(REL_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sys_n),
    .hold_i   (in_pulse),
    .svc_i    (svc_i),
    .tick_i   (tick),
    .reload_i (reload),
    .count_o  (count_o),
    .ovf_o    (ovf)
  );

  wdog_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_sys_n),
    .por_n    (por_n),
    .ovf_i    (ovf),
    .active_o (in_pulse),
    .cause_o  (wdt_cause_o)
  );

  assign reset_req_o = in_pulse;
  assign rst_out_n_o = !in_pulse;

  assert_svc_loads_R4: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (svc_i && !in_pulse) |=> (count_o == {$past(reload), {LOW_W{1'b0}}}));
  assert_ovf_pulls_low_R5: assert property (@(posedge clk) disable iff (!rst_sys_n)
    ovf |=> !rst_out_n_o);
  assert_fall_needs_ovf_R5: assert property (@(posedge clk) disable iff (!rst_sys_n)
    $fell(rst_out_n_o) |-> $past(ovf));
  assert_frozen_when_off_R7: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (!enabled && !svc_i) |=> $stable(count_o));
  assert_pulse_zero_R12: assert property (@(posedge clk) disable iff (!rst_sys_n)
    in_pulse |-> (count_o == '0));
endmodule

// File: tb/test_wdog_lockable.sv
module test_wdog_lockable;
  logic        clk = 1'b0;
  logic        rst_n, por_n, svc_i, einit_i, dis_i, cfg_we_i, cfg_slow_i;
  logic [7:0]  cfg_reload_i;
  logic [15:0] count_o;
  logic        reset_req_o, rst_out_n_o, wdt_cause_o;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  wdog_lockable i_wdog_lockable (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .svc_i(svc_i), .einit_i(einit_i),
    .dis_i(dis_i), .cfg_we_i(cfg_we_i), .cfg_slow_i(cfg_slow_i),
    .cfg_reload_i(cfg_reload_i), .count_o(count_o), .reset_req_o(reset_req_o),
    .rst_out_n_o(rst_out_n_o), .wdt_cause_o(wdt_cause_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(3); rst_n = 1'b1;
  endtask

  task automatic do_por();
    por_n = 1'b0; step(3); por_n = 1'b1;
  endtask

  task automatic svc();
    svc_i = 1'b1; step(1); svc_i = 1'b0;
  endtask

  task automatic einit();
    einit_i = 1'b1; step(1); einit_i = 1'b0;
  endtask

  task automatic dis();
    dis_i = 1'b1; step(1); dis_i = 1'b0;
  endtask

  task automatic cfg(input logic slow, input logic [7:0] rel);
    cfg_slow_i = slow; cfg_reload_i = rel; cfg_we_i = 1'b1;
    step(1); cfg_we_i = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1", "count", 32'(count_o), 32'h0);
    chk("R1", "rst_out_n", 32'(rst_out_n_o), 32'h1);
    chk("R1", "reset_req", 32'(reset_req_o), 32'h0);
    chk("R1", "cause", 32'(wdt_cause_o), 32'h0);
  endtask

  task automatic t_fast_rate();
    svc();                                    // default reload 0x00, fast (R1)
    chk("R1", "count after default service", 32'(count_o), 32'h0);
    step(1); chk("R2", "count at E1", 32'(count_o), 32'h0);
    step(1); chk("R2", "count at E2", 32'(count_o), 32'h1);
    step(18); chk("R2", "count at E20", 32'(count_o), 32'd10);
  endtask

  task automatic t_service_load();
    cfg(1'b0, 8'h5A);
    svc(); chk("R4", "load", 32'(count_o), 32'h5A00);
    step(1); chk("R4", "phase restart E1", 32'(count_o), 32'h5A00);
    step(1); chk("R4", "phase restart E2", 32'(count_o), 32'h5A01);
  endtask

  task automatic t_same_cycle();
    cfg(1'b0, 8'hFF);
    svc(); step(511);
    chk("R11", "count before edge", 32'(count_o), 32'hFFFF);
    svc();                                    // lands on the terminal tick
    chk("R11", "reloaded", 32'(count_o), 32'hFF00);
    chk("R11", "no pulse", 32'(rst_out_n_o), 32'h1);
    step(2); chk("R11", "counting on", 32'(count_o), 32'hFF01);
  endtask

  task automatic t_overflow_fast();
    svc(); step(511);
    chk("R5", "high before 512", 32'(rst_out_n_o), 32'h1);
    chk("R5", "count at E511", 32'(count_o), 32'hFFFF);
    step(1);
    chk("R5", "low at 512", 32'(rst_out_n_o), 32'h0);
    chk("R6", "req high", 32'(reset_req_o), 32'h1);
    chk("R10", "cause set", 32'(wdt_cause_o), 32'h1);
    chk("R6", "count cleared", 32'(count_o), 32'h0);
    svc();                                    // E513, inside the pulse
    chk("R12", "count held", 32'(count_o), 32'h0);
    step(14); chk("R12", "still low E527", 32'(rst_out_n_o), 32'h0);
    step(1);
    chk("R6", "released E528", 32'(rst_out_n_o), 32'h1);
    chk("R6", "req released", 32'(reset_req_o), 32'h0);
    chk("R6", "count zero at release", 32'(count_o), 32'h0);
    step(2); chk("R6", "restarted", 32'(count_o), 32'h1);
    do_reset();
    chk("R10", "cause kept over rst_n", 32'(wdt_cause_o), 32'h1);
    chk("R1", "count after rst_n", 32'(count_o), 32'h0);
    do_por();
    chk("R10", "cause cleared by por_n", 32'(wdt_cause_o), 32'h0);
  endtask

  task automatic t_slow();
    cfg(1'b1, 8'hFF);
    svc(); step(127);
    chk("R3", "no tick at E127", 32'(count_o), 32'hFF00);
    step(1); chk("R3", "tick at E128", 32'(count_o), 32'hFF01);
    step(128 * 254); chk("R3", "count at E32640", 32'(count_o), 32'hFFFF);
    step(127); chk("R5", "slow high at E32767", 32'(rst_out_n_o), 32'h1);
    step(1); chk("R5", "slow low at E32768", 32'(rst_out_n_o), 32'h0);
    step(16); chk("R6", "slow release", 32'(rst_out_n_o), 32'h1);
  endtask

  task automatic t_disable();
    logic [15:0] c0;
    do_reset();
    dis();
    c0 = count_o;
    step(300);
    chk("R7", "frozen count", 32'(count_o), 32'(c0));
    chk("R7", "no pulse", 32'(rst_out_n_o), 32'h1);
  endtask

  task automatic t_locked();
    do_reset();
    einit();
    cfg(1'b1, 8'h77);
    dis();
    svc();
    chk("R9", "reload unchanged", 32'(count_o), 32'h0);
    step(2); chk("R9", "still fast", 32'(count_o), 32'h1);
    step(8); chk("R8", "still enabled", 32'(count_o), 32'h5);
  endtask

  initial begin
    rst_n = 1'b0; por_n = 1'b0; svc_i = 1'b0; einit_i = 1'b0; dis_i = 1'b0;
    cfg_we_i = 1'b0; cfg_slow_i = 1'b0; cfg_reload_i = 8'h00;
    step(4);
    rst_n = 1'b1; por_n = 1'b1;
    t_reset_state();
    t_fast_rate();
    t_service_load();
    t_same_cycle();
    t_overflow_fast();
    t_slow();
    t_disable();
    t_locked();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule